// File: doc/BRIEF.md
# Deferred-Response SPI Command Slave

This block is an SPI slave in mode 0 that trades fixed 32-bit packets with a host processor. Each command carries a control byte, a 16-bit register address and an 8-bit data field. The block decodes the command and drives a one-port register-file interface. The reply to a command is not returned during the same transaction. It is assembled when the next transaction starts and shifted out during that transaction.

The format of each reply follows the read mode of the command before it. The default format carries the status byte, a 14-bit turn counter and a 10-bit angle. The register-read format carries the status byte, the addressed register's data and the upper part of the counter/angle word. The status flags, counter and angle come from outside the block. They are sampled when chip select falls. At that moment a one-cycle strobe goes to the status logic, so that it can clear its sticky event flags.

The SPI pins are brought into the system clock domain by synchronizer flops. The block runs from the system clock, which must be several times faster than the serial clock.

Top module: `deferred_cmd_spi_slave`

## Requirements
- R1: After reset, `miso` is 0, no write, read or position strobe is issued, and the first reply uses the position-and-status format.
- R2: Command bits arrive on `mosi` MSB first and are sampled on rising `sclk` while `csN` is low. The field positions are: bits 31:24 control byte, bits 23:8 address, bits 7:0 data. Inside the control byte, read mode is in bits 5:4 (packet bits 29:28) and write mode is in bits 1:0 (packet bits 25:24). The other control bits are ignored.
- R3: A complete packet with write mode 3 gives exactly one `regWrEn` pulse, with `regAddr` equal to packet bits 23:8 and `regWrData` equal to packet bits 7:0.
- R4: A complete packet with read mode 3 and write mode 0 gives exactly one `regRdEn` pulse with the packet's address, and no write. `regRdData` must be valid in the cycle after the `regRdEn` pulse.
- R5: The reply to a command is shifted out during the next transaction, never during the command's own transaction.
- R6: The position-and-status reply is `{2'b00, statFlags[5:0], mcCount[13:0], angle[9:0]}`. The flag bits are, from 5 down to 0: fatal fault, interrupt pending, zero capture lost, zero capture, rollover lost, rollover.
- R7: After a register-read command, the next reply is `{2'b00, statFlags, regData[7:0], mcCount[13:0], angle[9:8]}`, where regData is the value returned on the read port.
- R8: A transaction whose rising-`sclk` count is not 32 issues no write and no read, and leaves the pending reply format unchanged.
- R9: `posReadStb` pulses for exactly one cycle at the start of each transaction, when the reply is latched.
- R10: Reply bits leave on `miso` MSB first. Bit 31 is present before the first rising `sclk`, and each later bit follows a falling `sclk`.
- R11: Read mode 3 combined with a nonzero write mode issues no read. A write still happens when write mode is 3. Read modes 1 and 2 behave like mode 0. In all these cases the next reply uses the position-and-status format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host (idle low) |
| csN | input | 1 | Active-low chip select framing a packet |
| mosi | input | 1 | Serial command data from host |
| miso | output | 1 | Serial reply data to host |
| statFlags | input | 6 | Sticky status flags, fatal fault in bit 5 down to rollover in bit 0 |
| mcCount | input | 14 | Multi-turn counter value |
| angle | input | 10 | Angle within one turn |
| posReadStb | output | 1 | One-cycle pulse when a reply is latched |
| regWrEn | output | 1 | Register write strobe |
| regRdEn | output | 1 | Register read strobe |
| regAddr | output | 16 | Register address |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data, valid the cycle after regRdEn |

## Verification
The main function is exercised with several command sequences:
- A write followed by a register-read shows that the reply lags by one transaction and that its format switches on the previous read mode.
- A no-op after the read shows that the register-read reply carries the returned data together with counter and angle values that changed between transactions.
- A short packet sent between a read and a no-op shows that a partial frame neither strobes the register port nor resets the pending format.
- A read mode 3 command with a nonzero write mode, and a read mode 1 command, show how the block resolves the undefined mode combinations.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Strobes from the control block to the datapath.
  typedef struct packed {
    logic loadReply;  // chip select fell: latch reply
    logic shiftRx;    // rising sclk inside frame
    logic shiftTx;    // falling sclk inside frame
    logic cmdDone;    // frame closed with exact packet length
    logic capRead;    // register read data is valid now
  } ctrlStrb_t;

  localparam logic [1:0] RM_POS    = 2'd0;
  localparam logic [1:0] RM_REGPOS = 2'd3;
  localparam logic [1:0] WM_NONE   = 2'd0;
  localparam logic [1:0] WM_WRITE  = 2'd3;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= dIn;
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int PKT_W = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclkS,
  input  logic      csNS,
  output ctrlStrb_t strb
);

  localparam int CNT_W = $clog2(PKT_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PKT_W);

  logic sclkQ, csQ;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0] doneDly;
  logic sclkRise, sclkFall, csFall, csRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csQ   <= 1'b1;
    end else begin
      sclkQ <= sclkS;
      csQ   <= csNS;
    end
  end

  assign sclkRise = sclkS & ~sclkQ & ~csNS;
  assign sclkFall = ~sclkS & sclkQ & ~csNS;
  assign csFall   = ~csNS & csQ;
  assign csRise   = csNS & ~csQ;

  // Saturating bit counter: reset on frame start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (csFall) bitCnt <= '0;
    else if (sclkRise && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
  end

  // Read data returns two cycles after the frame closes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneDly <= '0;
    else doneDly <= {doneDly[0], strb.cmdDone};
  end

  always_comb begin
    strb.loadReply = csFall;
    strb.shiftRx   = sclkRise;
    strb.shiftTx   = sclkFall;
    strb.cmdDone   = csRise && (bitCnt == CNT_FULL);
    strb.capRead   = doneDly[1];
  end

  a_r8_cnt_cleared_at_frame: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadReply) |-> (bitCnt == '0));

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 14,
  parameter int ANG_W  = 10,
  parameter int FLAG_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              mosiS,
  input  logic [FLAG_W-1:0] statFlags,
  input  logic [CNT_W-1:0]  mcCount,
  input  logic [ANG_W-1:0]  angle,
  input  logic [DATA_W-1:0] regRdData,
  output logic              miso,
  output logic              posReadStb,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData
);

  localparam int CTRL_W = 8;
  localparam int PKT_W  = CTRL_W + ADDR_W + DATA_W;
  localparam int POS_W  = CNT_W + ANG_W;
  localparam int BODY_W = PKT_W - CTRL_W;
  localparam int TAIL_W = BODY_W - DATA_W;

  logic [PKT_W-1:0]  rxShift, txShift;
  logic [CTRL_W-1:0] ctrlByte;
  logic [1:0]        rdMode, wrMode;
  logic              isRegRead, pendingRegPos;
  logic [DATA_W-1:0] rdDataQ;
  logic [CTRL_W-1:0] statusByte;
  logic [POS_W-1:0]  posWord;
  logic [PKT_W-1:0]  replyPos, replyReg;

  // Receive shifter, MSB first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftRx) rxShift <= {rxShift[PKT_W-2:0], mosiS};
  end

  assign ctrlByte  = rxShift[PKT_W-1 -: CTRL_W];
  assign rdMode    = ctrlByte[5:4];
  assign wrMode    = ctrlByte[1:0];
  assign isRegRead = (rdMode == RM_REGPOS) && (wrMode == WM_NONE);

  // Command decode at frame close.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn       <= 1'b0;
      regRdEn       <= 1'b0;
      regAddr       <= '0;
      regWrData     <= '0;
      pendingRegPos <= 1'b0;
    end else if (strb.cmdDone) begin
      regWrEn       <= (wrMode == WM_WRITE);
      regRdEn       <= isRegRead;
      regAddr       <= rxShift[DATA_W +: ADDR_W];
      regWrData     <= rxShift[DATA_W-1:0];
      pendingRegPos <= isRegRead;
    end else begin
      regWrEn <= 1'b0;
      regRdEn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdDataQ <= '0;
    else if (strb.capRead && pendingRegPos) rdDataQ <= regRdData;
  end

  // Reply assembly.
  assign statusByte = {{(CTRL_W-FLAG_W){1'b0}}, statFlags};
  assign posWord    = {mcCount, angle};

  generate
    if (POS_W >= BODY_W) begin : gPosFit
      assign replyPos = {statusByte, posWord[POS_W-1 -: BODY_W]};
    end else begin : gPosPad
      assign replyPos = {statusByte, posWord, {(BODY_W-POS_W){1'b0}}};
    end
    if (POS_W >= TAIL_W) begin : gRegFit
      assign replyReg = {statusByte, rdDataQ, posWord[POS_W-1 -: TAIL_W]};
    end else begin : gRegPad
      assign replyReg = {statusByte, rdDataQ, posWord, {(TAIL_W-POS_W){1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift    <= '0;
      posReadStb <= 1'b0;
    end else begin
      posReadStb <= strb.loadReply;
      if (strb.loadReply) txShift <= pendingRegPos ? replyReg : replyPos;
      else if (strb.shiftTx) txShift <= {txShift[PKT_W-2:0], 1'b0};
    end
  end

  assign miso = txShift[PKT_W-1];

  a_r3_write_follows_frame: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(strb.cmdDone));
  a_r4_read_follows_frame: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |-> $past(strb.cmdDone));
  a_r11_no_read_with_write: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |-> !regWrEn);
  a_r9_single_stb: assert property (@(posedge clk) disable iff (!rstN)
    posReadStb |=> !posReadStb);
  a_r7_capture_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capRead && pendingRegPos) |-> $past(regRdEn));

endmodule

// File: rtl/deferred_cmd_spi_slave.sv
module deferred_cmd_spi_slave
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 14,
  parameter int ANG_W  = 10,
  parameter int FLAG_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  logic [FLAG_W-1:0] statFlags,
  input  logic [CNT_W-1:0]  mcCount,
  input  logic [ANG_W-1:0]  angle,
  output logic              posReadStb,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData
);

  localparam int PKT_W = 8 + ADDR_W + DATA_W;

  logic [2:0] pinSync;
  ctrlStrb_t  strb;

  spi_cmd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
    .clk(clk), .rstN(rstN), .dIn({sclk, csN, mosi}), .dOut(pinSync)
  );

  spi_cmd_ctrl #(.PKT_W(PKT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclkS(pinSync[2]), .csNS(pinSync[1]), .strb(strb)
  );

  spi_cmd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .ANG_W(ANG_W), .FLAG_W(FLAG_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiS(pinSync[0]),
    .statFlags(statFlags), .mcCount(mcCount), .angle(angle),
    .regRdData(regRdData), .miso(miso), .posReadStb(posReadStb),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData)
  );

endmodule

// File: tb/deferred_cmd_spi_slave_tb_top.sv
module deferred_cmd_spi_slave_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, posReadStb, regWrEn, regRdEn;
  logic [5:0]  statFlags = '0;
  logic [13:0] mcCount = '0;
  logic [9:0]  angle = '0;
  logic [15:0] regAddr;
  logic [7:0]  regWrData, regRdData;

  int checks = 0, fails = 0;
  int wrCnt = 0, rdCnt = 0, stbCnt = 0;
  logic [15:0] lastWrAddr, lastRdAddr;
  logic [7:0]  lastWrData;
  logic [7:0]  mem [16];
  bit done = 0;

  always #10 clk = ~clk;

  deferred_cmd_spi_slave dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .statFlags(statFlags), .mcCount(mcCount), .angle(angle),
    .posReadStb(posReadStb), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  // Register file model with one-cycle read latency.
  always @(posedge clk) begin
    if (regRdEn) regRdData <= mem[regAddr[3:0]];
    if (regWrEn) mem[regAddr[3:0]] <= regWrData;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn) begin wrCnt++; lastWrAddr = regAddr; lastWrData = regWrData; end
      if (regRdEn) begin rdCnt++; lastRdAddr = regAddr; end
      if (posReadStb) stbCnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic [1:0] rm, input logic [1:0] wm,
                                        input logic [15:0] a, input logic [7:0] d);
    return {2'b00, rm, 2'b00, wm, a, d};
  endfunction

  function automatic logic [31:0] posReply();
    return {2'b00, statFlags, mcCount, angle};
  endfunction

  function automatic logic [31:0] regReply(input logic [7:0] d);
    return {2'b00, statFlags, d, mcCount, angle[9:8]};
  endfunction

  task automatic xfer(input logic [31:0] cmd, input int nbits, output logic [31:0] resp);
    resp = '0;
    @(negedge clk); csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = cmd[31 - (i % 32)];
      repeat (6) @(negedge clk);
      if (i < 32) resp[31-i] = miso;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 miso idle", {31'd0, miso}, 32'd0);
    check("R1 no strobes", wrCnt + rdCnt + stbCnt, 0);
  endtask

  task automatic t_write_first();
    logic [31:0] r;
    statFlags = 6'h2A; mcCount = 14'h1234; angle = 10'h2AB;
    xfer(mkCmd(2'd0, 2'd3, 16'h0005, 8'hA5), 32, r);
    check("R1 R6 R10 first reply position format", r, {2'b00, 6'h2A, 14'h1234, 10'h2AB});
    check("R3 one write", wrCnt, 1);
    check("R2 R3 write address", {16'd0, lastWrAddr}, 32'h0005);
    check("R2 R3 write data", {24'd0, lastWrData}, 32'hA5);
    check("R9 strobe per frame", stbCnt, 1);
    check("R4 no read on write", rdCnt, 0);
  endtask

  task automatic t_read_deferred();
    logic [31:0] r;
    statFlags = 6'h01; mcCount = 14'h3FFF; angle = 10'h155;
    xfer(mkCmd(2'd3, 2'd0, 16'h0005, 8'h00), 32, r);
    check("R5 read reply deferred", r, posReply());
    check("R4 one read", rdCnt, 1);
    check("R4 read address", {16'd0, lastRdAddr}, 32'h0005);
    check("R4 no write", wrCnt, 1);
    statFlags = 6'h3C; mcCount = 14'h0ACE; angle = 10'h3C3;
    xfer(mkCmd(2'd0, 2'd0, 16'h0000, 8'h00), 32, r);
    check("R7 register reply format", r, regReply(8'hA5));
    check("R9 strobe count", stbCnt, 3);
  endtask

  task automatic t_discard();
    logic [31:0] r;
    mem[7] = 8'h3C;
    xfer(mkCmd(2'd3, 2'd0, 16'h0007, 8'h00), 32, r);
    check("R6 nop reply position", r, posReply());
    xfer(mkCmd(2'd0, 2'd3, 16'h0009, 8'h77), 20, r);
    check("R8 short frame no write", wrCnt, 1);
    check("R8 short frame no read", rdCnt, 2);
    xfer(mkCmd(2'd0, 2'd3, 16'h0009, 8'h77), 40, r);
    check("R8 long frame no write", wrCnt, 1);
    statFlags = 6'h15; mcCount = 14'h2001; angle = 10'h0FF;
    xfer(mkCmd(2'd0, 2'd0, 16'h0000, 8'h00), 32, r);
    check("R8 pending format kept", r, regReply(8'h3C));
  endtask

  task automatic t_undefined_modes();
    logic [31:0] r;
    xfer(mkCmd(2'd3, 2'd3, 16'h0002, 8'h11), 32, r);
    check("R11 write still happens", wrCnt, 2);
    check("R11 write data", {24'd0, lastWrData}, 32'h11);
    check("R11 no read", rdCnt, 2);
    statFlags = 6'h20; mcCount = 14'h0001; angle = 10'h200;
    xfer(mkCmd(2'd1, 2'd0, 16'h0003, 8'h00), 32, r);
    check("R11 reply position after rm3 wm3", r, posReply());
    statFlags = 6'h08; mcCount = 14'h1111; angle = 10'h001;
    xfer(mkCmd(2'd0, 2'd0, 16'h0000, 8'h00), 32, r);
    check("R11 rm1 gives position reply", r, posReply());
    check("R11 rm1 no read", rdCnt, 2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i);
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_first();
    t_read_deferred();
    t_discard();
    t_undefined_modes();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule